// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines into one raw level vector. It drives two processor request outputs from that vector: a normal request (IRQ) and a fast request (FIQ). Each output has its own enable mask, and an output is high whenever any raw bit is set that its mask also enables. Line 0 can also be raised or lowered by software, so a driver can post an interrupt to itself.

Software uses a word-indexed register bus with separate read and write strobes. Enables are changed through write-one-to-set and write-one-to-clear locations, so a driver never has to read, modify and write back a mask. Each output has a masked status view and a raw status view. Accesses to a location that does not support that direction are flagged as bad. A bad read returns zero, and a bad write changes nothing. Priority, vectoring and edge capture are left to other logic.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: `irq_o` is high exactly when the bitwise AND of the raw vector and the IRQ enable mask is nonzero, both taken as registered at the last clock edge.
- R2: `fiq_o` follows the same rule using the FIQ enable mask, which is independent of the IRQ mask.
- R3: A write to word index 2 ORs the written data into the IRQ enable mask. A write to index 10 does the same for the FIQ enable mask.
- R4: A write to word index 3 clears each IRQ enable bit whose data bit is 1. A write to index 11 does the same for the FIQ enable mask. Bits written as 0 are left unchanged.
- R5: A read returns its data on `bus_rdata` in the cycle after `bus_rd`. The read map is: index 0 gives raw AND IRQ mask, indices 1 and 9 give the raw vector, index 2 gives the IRQ mask, index 4 gives raw bit 0 in bit 0 with all other bits zero, index 8 gives raw AND FIQ mask, and index 10 gives the FIQ mask.
- R6: A read at index 3, 5, 11 or any unlisted index is bad, and so is a write at index 0, 1, 8, 9 or any unlisted index. For a bad access, `bus_bad` is high in the following cycle. A bad read returns zero, and a bad write leaves all state unchanged.
- R7: A write to index 4 with data bit 0 set raises raw bit 0. A write to index 5 with data bit 0 set lowers it. The other data bits have no effect, and a write with bit 0 clear does nothing.
- R8: For every line other than 0, the raw bit takes the level of `src_i` at each clock edge.
- R9: Raw bit 0 is decided by whichever event came last: a level change on `src_i[0]`, or a software raise or lower. If both occur at the same edge, the software action wins. A steady level on `src_i[0]` does not undo a software action.
- R10: While `rst_n` is low at an edge, both masks clear to zero, the raw vector loads `src_i`, and `bus_rdata` and `bus_bad` become zero.
- R11: A mask write changes `irq_o` and `fiq_o` at the clock edge that accepts the write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC (32) | Level interrupt lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (6) | Word index |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after `bus_rd` |
| bus_bad | output | 1 | One-cycle flag for a bad access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A change on a source line reaches the raw vector at the next edge, and it reaches `irq_o`/`fiq_o` in the same cycle, because the outputs are combinational from the registers. A mask write takes effect at the edge that accepts it. Read data and the bad flag are due one edge after the strobe. The bench drives every stimulus on a falling edge and samples just after the next falling edge, so each result is read exactly one edge after it was caused. For the mask-write timing, the bench also samples once before the accepting edge to confirm that the outputs have not moved yet.

// File: rtl/irqfiq_pkg.sv
// Shared constants and types for the dual-output interrupt controller.
// Assumes word indices fit in the bus address width chosen at the top.
package irqfiq_pkg;

    localparam int IDX_IRQ_MASKED = 0;
    localparam int IDX_IRQ_RAW    = 1;
    localparam int IDX_IRQ_EN_SET = 2;
    localparam int IDX_IRQ_EN_CLR = 3;
    localparam int IDX_SOFT_SET   = 4;
    localparam int IDX_SOFT_CLR   = 5;
    localparam int IDX_FIQ_MASKED = 8;
    localparam int IDX_FIQ_RAW    = 9;
    localparam int IDX_FIQ_EN_SET = 10;
    localparam int IDX_FIQ_EN_CLR = 11;

    // Number of request outputs, each with its own mask
    localparam int NUM_OUT = 2;
    localparam int OUT_IRQ = 0;
    localparam int OUT_FIQ = 1;

    // Read source selected by the decoder
    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_IRQ_MASKED,
        RSEL_RAW,
        RSEL_IRQ_EN,
        RSEL_SOFT,
        RSEL_FIQ_MASKED,
        RSEL_FIQ_EN
    } rsel_e;

    // Write commands decoded from one bus write
    typedef struct packed {
        logic [NUM_OUT-1:0] en_set;
        logic [NUM_OUT-1:0] en_clr;
        logic               soft_set;
        logic               soft_clr;
    } wcmd_t;

endpackage

// File: rtl/irqfiq_decode.sv
// Address decoder: maps a strobed word index to write commands, a read
// source and a bad-access flag. Purely combinational; assumes the
// strobes are single-cycle qualified by the caller.
module irqfiq_decode
    import irqfiq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata_lsb,
    output wcmd_t             wcmd,
    output rsel_e             rsel,
    output logic              bad_rd,
    output logic              bad_wr
);

    // Write side: turn an index into set/clear commands or a bad flag
    always_comb begin
        wcmd   = '0;
        bad_wr = 1'b0;
        if (wr_en) begin
            if (addr == ADDR_W'(IDX_IRQ_EN_SET))      wcmd.en_set[OUT_IRQ] = 1'b1;
            else if (addr == ADDR_W'(IDX_IRQ_EN_CLR)) wcmd.en_clr[OUT_IRQ] = 1'b1;
            else if (addr == ADDR_W'(IDX_FIQ_EN_SET)) wcmd.en_set[OUT_FIQ] = 1'b1;
            else if (addr == ADDR_W'(IDX_FIQ_EN_CLR)) wcmd.en_clr[OUT_FIQ] = 1'b1;
            else if (addr == ADDR_W'(IDX_SOFT_SET))   wcmd.soft_set = wdata_lsb;
            else if (addr == ADDR_W'(IDX_SOFT_CLR))   wcmd.soft_clr = wdata_lsb;
            else                                      bad_wr = 1'b1;
        end
    end

    // Read side: pick the view to return or flag the read as bad
    always_comb begin
        rsel   = RSEL_NONE;
        bad_rd = 1'b0;
        if (rd_en) begin
            if (addr == ADDR_W'(IDX_IRQ_MASKED))      rsel = RSEL_IRQ_MASKED;
            else if (addr == ADDR_W'(IDX_IRQ_RAW))    rsel = RSEL_RAW;
            else if (addr == ADDR_W'(IDX_IRQ_EN_SET)) rsel = RSEL_IRQ_EN;
            else if (addr == ADDR_W'(IDX_SOFT_SET))   rsel = RSEL_SOFT;
            else if (addr == ADDR_W'(IDX_FIQ_MASKED)) rsel = RSEL_FIQ_MASKED;
            else if (addr == ADDR_W'(IDX_FIQ_RAW))    rsel = RSEL_RAW;
            else if (addr == ADDR_W'(IDX_FIQ_EN_SET)) rsel = RSEL_FIQ_EN;
            else                                      bad_rd = 1'b1;
        end
    end

endmodule

// File: rtl/irqfiq_mask.sv
// One enable mask with write-one-to-set and write-one-to-clear strobes.
// Assumes set and clear never arrive in the same cycle (distinct indices).
module irqfiq_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    // Mask register: OR in on set, AND out on clear, zero on reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (set_stb) mask_q <= mask_q | wdata;
        else if (clr_stb) mask_q <= mask_q & ~wdata;
    end

    p_set_adds_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((mask_q & $past(wdata)) == $past(wdata)));

    p_set_keeps_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

    p_clr_drops_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((mask_q & $past(wdata)) == '0));

    p_clr_keeps_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (mask_q == ($past(mask_q) & ~$past(wdata))));

endmodule

// File: rtl/irqfiq_raw.sv
// Raw level vector. Lines 1..W-1 copy their input each edge; line 0 also
// accepts software raise/lower, the most recent event winning, software
// first when both land on one edge. Reset loads the inputs directly.
module irqfiq_raw #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         soft_set,
    input  logic         soft_clr,
    output logic [W-1:0] raw_q
);

    logic line0_prev;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_soft
            // Line 0: track input changes and software events
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    raw_q[0]   <= src_i[0];
                    line0_prev <= src_i[0];
                end else begin
                    line0_prev <= src_i[0];
                    if (soft_set)                    raw_q[0] <= 1'b1;
                    else if (soft_clr)               raw_q[0] <= 1'b0;
                    else if (src_i[0] != line0_prev) raw_q[0] <= src_i[0];
                end
            end
        end else begin : g_hw
            // Plain hardware line: follow the input level
            always_ff @(posedge clk) begin
                raw_q[i] <= src_i[i];
            end
        end
    end

    if (W > 1) begin : g_follow_chk
        p_lines_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (raw_q[W-1:1] == $past(src_i[W-1:1])));
    end

    p_soft_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_set |=> raw_q[0]);

    p_soft_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_clr && !soft_set) |=> !raw_q[0]);

    p_line0_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_set && !soft_clr && src_i[0] == line0_prev) |=> $stable(raw_q[0]));

endmodule

// File: rtl/irq_fiq_ctrl.sv
// Dual-output level interrupt controller top. Combines the decoder, the
// raw vector and one enable mask per output; drives the two requests
// combinationally from registered state and returns read data one
// cycle after the read strobe. Assumes NSRC <= DATA_W.
module irq_fiq_ctrl
    import irqfiq_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_bad,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int PAD_W = DATA_W - NSRC;

    wcmd_t           wcmd;
    rsel_e           rsel;
    logic            bad_rd;
    logic            bad_wr;
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] mask_q [NUM_OUT];
    logic [NSRC-1:0] hit    [NUM_OUT];
    logic [NSRC-1:0] rd_val;

    irqfiq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata_lsb (bus_wdata[0]),
        .wcmd      (wcmd),
        .rsel      (rsel),
        .bad_rd    (bad_rd),
        .bad_wr    (bad_wr)
    );

    irqfiq_raw #(.W(NSRC)) u_raw (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .soft_set (wcmd.soft_set),
        .soft_clr (wcmd.soft_clr),
        .raw_q    (raw_q)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        irqfiq_mask #(.W(NSRC)) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (wcmd.en_set[k]),
            .clr_stb (wcmd.en_clr[k]),
            .wdata   (bus_wdata[NSRC-1:0]),
            .mask_q  (mask_q[k])
        );
        // Per-output pending bits
        always_comb hit[k] = raw_q & mask_q[k];
    end

    // Request outputs from registered raw and mask state
    always_comb begin
        irq_o = |hit[OUT_IRQ];
        fiq_o = |hit[OUT_FIQ];
    end

    // Read multiplexer over the selected view
    always_comb begin
        case (rsel)
            RSEL_IRQ_MASKED: rd_val = hit[OUT_IRQ];
            RSEL_RAW:        rd_val = raw_q;
            RSEL_IRQ_EN:     rd_val = mask_q[OUT_IRQ];
            RSEL_SOFT:       rd_val = NSRC'(raw_q[0]);
            RSEL_FIQ_MASKED: rd_val = hit[OUT_FIQ];
            RSEL_FIQ_EN:     rd_val = mask_q[OUT_FIQ];
            default:         rd_val = '0;
        endcase
    end

    // Registered read data and bad-access flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_bad   <= 1'b0;
        end else begin
            bus_rdata <= {{PAD_W{1'b0}}, rd_val};
            bus_bad   <= bad_rd | bad_wr;
        end
    end

    p_irq_clear_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(IDX_IRQ_EN_CLR) && (&bus_wdata[NSRC-1:0])) |=> !irq_o);

    p_fiq_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(IDX_FIQ_EN_CLR) && (&bus_wdata[NSRC-1:0])) |=> !fiq_o);

    p_bad_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(IDX_IRQ_EN_CLR)) |=> (bus_bad && bus_rdata == '0));

    p_bad_write_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bad_wr) |=> ($stable(mask_q[OUT_IRQ]) && $stable(mask_q[OUT_FIQ])));

    p_soft_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(IDX_SOFT_SET)) |=> (bus_rdata[DATA_W-1:1] == '0));

endmodule

// File: tb/tb_irq_fiq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_irq_fiq_ctrl;

    localparam int NSRC   = 32;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_i = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_bad;
    logic              irq_o;
    logic              fiq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    irq_fiq_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_bad(bus_bad),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(idx); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input int idx, output logic [31:0] d, output logic bad);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(idx);
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        d = bus_rdata; bad = bus_bad;
    endtask

    task automatic drive_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] d; logic b;
        src_i = 32'h0000_0004;
        repeat (3) @(negedge clk);
        #1;
        check(bus_rdata == 0, "R10 rdata", bus_rdata, 0);
        check(!bus_bad, "R10 bad", 32'(bus_bad), 0);
        rst_n = 1'b1;
        rd(2, d, b);  check(d == 0, "R10 irq mask", d, 0);
        rd(10, d, b); check(d == 0, "R10 fiq mask", d, 0);
        rd(1, d, b);  check(d == 32'h4, "R10 raw loaded", d, 32'h4);
        check(!irq_o && !fiq_o, "R10 outputs", {irq_o, fiq_o}, 0);
        drive_src(0);
    endtask

    task automatic t_enable_set_clear();
        logic [31:0] d; logic b;
        wr(2, 32'h0000_00F0);
        wr(2, 32'h0000_0F00);
        rd(2, d, b);  check(d == 32'h0FF0, "R3 irq set or", d, 32'h0FF0);
        wr(3, 32'h0000_0030);
        rd(2, d, b);  check(d == 32'h0FC0, "R4 irq clear", d, 32'h0FC0);
        wr(10, 32'h8000_0001);
        wr(10, 32'h0000_0100);
        rd(10, d, b); check(d == 32'h8000_0101, "R3 fiq set or", d, 32'h8000_0101);
        wr(11, 32'h0000_0001);
        rd(10, d, b); check(d == 32'h8000_0100, "R4 fiq clear", d, 32'h8000_0100);
        rd(2, d, b);  check(d == 32'h0FC0, "R4 irq mask independent", d, 32'h0FC0);
    endtask

    task automatic t_outputs();
        logic [31:0] d; logic b;
        drive_src(32'h0000_0040);
        check(irq_o, "R1 irq on enabled line", 32'(irq_o), 1);
        check(!fiq_o, "R2 fiq off", 32'(fiq_o), 0);
        rd(0, d, b);  check(d == 32'h40, "R5 irq masked view", d, 32'h40);
        rd(1, d, b);  check(d == 32'h40, "R5 raw view", d, 32'h40);
        drive_src(32'h0000_0002);
        check(!irq_o, "R1 irq off disabled line", 32'(irq_o), 0);
        drive_src(32'h8000_0400);
        check(fiq_o, "R2 fiq on", 32'(fiq_o), 1);
        check(irq_o, "R1 irq shared raw", 32'(irq_o), 1);
        rd(8, d, b);  check(d == 32'h8000_0000, "R5 fiq masked view", d, 32'h8000_0000);
        rd(9, d, b);  check(d == 32'h8000_0400, "R8 raw follows lines", d, 32'h8000_0400);
        drive_src(0);
        check(!irq_o && !fiq_o, "R8 lines drop", {irq_o, fiq_o}, 0);
    endtask

    task automatic t_mask_timing();
        drive_src(32'h0001_0000);
        check(!irq_o, "R11 pre", 32'(irq_o), 0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(2); bus_wdata = 32'h0001_0000;
        #1;
        check(!irq_o, "R11 not before edge", 32'(irq_o), 0);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check(irq_o, "R11 at accepting edge", 32'(irq_o), 1);
        wr(3, 32'h0001_0000);
        check(!irq_o, "R11 clear effect", 32'(irq_o), 0);
        drive_src(0);
    endtask

    task automatic t_soft();
        logic [31:0] d; logic b;
        wr(2, 32'h1);
        wr(4, 32'hFFFF_FFFE);
        rd(4, d, b);  check(d == 0, "R7 set without bit0 ignored", d, 0);
        check(!irq_o, "R7 no irq", 32'(irq_o), 0);
        wr(4, 32'h1);
        rd(4, d, b);  check(d == 1, "R7 soft raise", d, 1);
        check(irq_o, "R7 irq from soft", 32'(irq_o), 1);
        wr(5, 32'hFFFF_FFFE);
        rd(1, d, b);  check(d == 1, "R7 clear without bit0 ignored", d, 1);
        wr(5, 32'h1);
        rd(4, d, b);  check(d == 0, "R7 soft lower", d, 0);
    endtask

    task automatic t_last_event();
        logic [31:0] d; logic b;
        drive_src(32'h1);
        rd(4, d, b);  check(d == 1, "R9 line0 rise", d, 1);
        wr(5, 32'h1);
        rd(4, d, b);  check(d == 0, "R9 soft lower beats held line", d, 0);
        repeat (3) @(negedge clk);
        rd(4, d, b);  check(d == 0, "R9 held line does not undo", d, 0);
        drive_src(32'h0);
        drive_src(32'h1);
        rd(4, d, b);  check(d == 1, "R9 fresh rise wins", d, 1);
        // Same edge: line 0 falls while software raises
        @(negedge clk);
        src_i = 32'h0; bus_wr = 1'b1; bus_addr = ADDR_W'(4); bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4, d, b);  check(d == 1, "R9 software wins same edge", d, 1);
        wr(5, 32'h1);
        wr(3, 32'hFFFF_FFFF);
        wr(11, 32'hFFFF_FFFF);
    endtask

    task automatic t_bad();
        logic [31:0] d; logic b;
        rd(3, d, b);  check(b && d == 0, "R6 read clear index", {b, d[30:0]}, 32'h8000_0000);
        rd(5, d, b);  check(b && d == 0, "R6 read soft clear index", {b, d[30:0]}, 32'h8000_0000);
        rd(12, d, b); check(b && d == 0, "R6 read unlisted", {b, d[30:0]}, 32'h8000_0000);
        rd(2, d, b);  check(!b, "R6 good read not flagged", 32'(b), 0);
        wr(0, 32'hFFFF_FFFF);
        check(bus_bad, "R6 write status flagged", 32'(bus_bad), 1);
        wr(9, 32'hFFFF_FFFF);
        check(bus_bad, "R6 write raw flagged", 32'(bus_bad), 1);
        rd(2, d, b);  check(d == 0, "R6 bad write no irq mask change", d, 0);
        rd(10, d, b); check(d == 0, "R6 bad write no fiq mask change", d, 0);
        rd(1, d, b);  check(d == 0, "R6 bad write no raw change", d, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_enable_set_clear();
        t_outputs();
        t_mask_timing();
        t_soft();
        t_last_event();
        t_bad();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule